// File: doc/BRIEF.md
# Debug Port Transaction Sequencer

This block sits on the host side of a debug link. It accepts one register-level request at a time and turns it into an ordered series of 35-bit debug-port scans: a 3-bit acknowledge/address/direction header plus a 32-bit data word. The scans go out one at a time through a valid/ready scan-request port. A driver elsewhere shifts the bits and returns the captured acknowledge and data. Reads are posted, so the block fetches each read result with a follow-up scan of the read buffer. Block reads are pipelined: every scan starts the next read and collects the previous word.

The sequencer keeps a one-entry cache of the access-port bank. It writes the select register only when an access-port request targets a bank other than the cached one. It tags scans to memory data registers with a programmable count of idle clocks. A dedicated check request reads the control/status register and repeats the read while the acknowledge says WAIT, up to a cycle limit. It then reports a protocol error, a timeout, a cleared sticky error, or a need to re-initialise the debug port.

Top module: `dbg_txn_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and both `scan_valid` and `rsp_valid` are 0.
- R2: An access-port request (op 2, 3 or 4) whose address bits [7:4] differ from the cached bank is preceded by a scan with instruction 0xA, address 2'b10, direction write and data `{req_apsel, 16'h0, req_addr[7:4], 4'h0}`. The cache starts invalid at reset. A later request to the same bank issues no such scan.
- R3: A single read (op 0 or 2) is an access scan (instruction 0xA for op 0, 0xB for op 2, address `req_addr[3:2]`, direction read) followed by a read-buffer scan (0xA, address 2'b11, read). The response data equals the data captured by the second scan, and `rsp_last` is 1.
- R4: A write (op 1 or 3) is a single scan with direction write and data `req_wdata`. It answers with status 0.
- R5: A block read (op 4) of N words (N=0 treated as 1) issues N access-port read scans, then one read-buffer scan. It returns N responses: word k carries the data of scan k+1. Only the final word has `rsp_last` set.
- R6: `scan_idle` equals `cfg_idle_tck` on instruction-0xB scans to address 0x0C or 0x10..0x1F. It is 0 on every other scan.
- R7: An abort (op 5) is one scan with instruction 0x8, address 0, direction write and data 1.
- R8: A check (op 6) reads CTRL/STAT (0xA, address 2'b01, read) and then the read buffer. If the read-buffer acknowledge is 3'b010 and bits 1 and 5 of its data are clear, the status is 0 and the data is that word.
- R9: In a check, an acknowledge of 3'b001 repeats the scan pair. Once `TIMEOUT_CYC` cycles have passed since the check began, a WAIT ends the check with status 2.
- R10: In a check, an acknowledge other than 3'b001 or 3'b010 ends it with status 1.
- R11: If bit 1 or bit 5 is set and bits [31:28] are all ones, the block writes CTRL/STAT (0xA, address 2'b01, write) with `req_wdata | 32'h22` and ends with status 3.
- R12: If bit 1 or bit 5 is set and bits [31:28] are not all ones, the check ends with status 4 and no further scan.
- R13: While `scan_valid` is high and `scan_ready` is low, all scan request fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_idle_tck | input | IDLE_W | Idle clocks to attach to memory data scans |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 3 | 0 dp read, 1 dp write, 2 ap read, 3 ap write, 4 ap block read, 5 abort, 6 check |
| req_addr | input | 8 | Register address; [7:4] bank, [3:2] scan address |
| req_wdata | input | 32 | Write data, or CTRL/STAT base value for a check |
| req_count | input | CNT_W | Word count for block reads |
| req_apsel | input | 8 | Current access-port number for select writes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Read data or CTRL/STAT value |
| rsp_status | output | 3 | 0 ok, 1 bad ack, 2 timeout, 3 sticky cleared, 4 re-init needed |
| rsp_last | output | 1 | Final response of the request |
| scan_valid | output | 1 | Scan request present |
| scan_ready | input | 1 | Scan request taken |
| scan_ir | output | 4 | Instruction: 0x8 abort, 0xA debug-port, 0xB access-port |
| scan_addr | output | 2 | Register address bits [3:2] |
| scan_rnw | output | 1 | 1 read, 0 write |
| scan_wdata | output | 32 | Data shifted in |
| scan_idle | output | IDLE_W | Idle clocks to run after the scan |
| scan_rsp_valid | input | 1 | Scan result present |
| scan_rsp_ack | input | 3 | Captured acknowledge |
| scan_rsp_rdata | input | 32 | Captured data |

## Verification
On every cycle, the assertions check that a stalled scan request holds its fields and that abort scans always carry write data 1. They also check that idle clocks appear only on access-port scans, that the bank cache hits right after an update, that the timeout counter restarts on a new check, and that a final response leaves the block ready. Only the directed scenarios can show the order and count of scans, and the posted-data offset in pipelined block reads. The same holds for whether the select write is skipped when the bank matches, for how many WAIT retries happen, and for which status each CTRL/STAT value yields.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
    localparam logic [3:0] IR_ABORT = 4'h8;
    localparam logic [3:0] IR_DPACC = 4'hA;
    localparam logic [3:0] IR_APACC = 4'hB;

    localparam logic [1:0] DPA_CSR    = 2'b01;
    localparam logic [1:0] DPA_SELECT = 2'b10;
    localparam logic [1:0] DPA_RDBUF  = 2'b11;

    localparam logic [2:0] ACK_WAIT = 3'b001;
    localparam logic [2:0] ACK_OK   = 3'b010;

    localparam int STICKY_ORUN_BIT = 1;
    localparam int STICKY_ERR_BIT  = 5;
    localparam logic [31:0] STICKY_MASK = 32'h0000_0022;

    typedef enum logic [2:0] {
        OP_DP_RD  = 3'd0,
        OP_DP_WR  = 3'd1,
        OP_AP_RD  = 3'd2,
        OP_AP_WR  = 3'd3,
        OP_AP_BLK = 3'd4,
        OP_ABORT  = 3'd5,
        OP_CHECK  = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_BADACK  = 3'd1,
        ST_TIMEOUT = 3'd2,
        ST_STICKY  = 3'd3,
        ST_REINIT  = 3'd4
    } status_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_SEL, PH_ACC, PH_BLK, PH_RDB,
        PH_CHK_CS, PH_CHK_RDB, PH_CLR, PH_ABORT
    } phase_e;
endpackage

// File: rtl/dbg_bank_cache.sv
module dbg_bank_cache #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    output logic              hit,
    input  logic              upd,
    input  logic [BANK_W-1:0] upd_bank
);
    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] bank;
    } cache_t;

    cache_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (upd) begin
            c_d.valid = 1'b1;
            c_d.bank  = upd_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign hit = c_q.valid && (c_q.bank == look_bank);

    // R2
    cache_hit_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd) && (look_bank == $past(upd_bank))) |-> hit);
endmodule

// File: rtl/dbg_tmo_timer.sv
module dbg_tmo_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= LIM);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                  cnt_d = '0;
        else if (run && !expired) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !expired);
endmodule

// File: rtl/dbg_txn_seq.sv
module dbg_txn_seq
    import dbg_seq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int IDLE_W      = 8,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDLE_W-1:0] cfg_idle_tck,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [7:0]        req_apsel,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic [2:0]        rsp_status,
    output logic              rsp_last,
    output logic              scan_valid,
    input  logic              scan_ready,
    output logic [3:0]        scan_ir,
    output logic [1:0]        scan_addr,
    output logic              scan_rnw,
    output logic [31:0]       scan_wdata,
    output logic [IDLE_W-1:0] scan_idle,
    input  logic              scan_rsp_valid,
    input  logic [2:0]        scan_rsp_ack,
    input  logic [31:0]       scan_rsp_rdata
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic              pend;
        op_e               op;
        logic [7:0]        addr;
        logic [31:0]       wdata;
        logic [CNT_W-1:0]  rem;
        logic [7:0]        apsel;
        logic              rsp_valid;
        logic [31:0]       rsp_data;
        status_e           rsp_status;
        logic              rsp_last;
    } seq_t;

    seq_t s_d, s_q;

    logic cache_hit, cache_upd;
    logic tmr_clr, tmr_run, tmr_exp;

    dbg_bank_cache #(.BANK_W(4)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_bank (req_addr[7:4]),
        .hit       (cache_hit),
        .upd       (cache_upd),
        .upd_bank  (s_q.addr[7:4])
    );

    dbg_tmo_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    function automatic logic is_ap(input op_e op);
        return (op == OP_AP_RD) || (op == OP_AP_WR) || (op == OP_AP_BLK);
    endfunction

    function automatic logic mem_data_reg(input logic [7:0] a);
        return (a == 8'h0C) || (a[7:4] == 4'h1);
    endfunction

    assign tmr_run = (s_q.phase == PH_CHK_CS) || (s_q.phase == PH_CHK_RDB);

    // scan request fields follow the registered phase only
    always_comb begin
        scan_ir    = IR_DPACC;
        scan_addr  = DPA_RDBUF;
        scan_rnw   = 1'b1;
        scan_wdata = '0;
        scan_idle  = '0;
        unique case (s_q.phase)
            PH_SEL: begin
                scan_addr  = DPA_SELECT;
                scan_rnw   = 1'b0;
                scan_wdata = {s_q.apsel, 16'h0, s_q.addr[7:4], 4'h0};
            end
            PH_ACC, PH_BLK: begin
                scan_ir   = is_ap(s_q.op) ? IR_APACC : IR_DPACC;
                scan_addr = s_q.addr[3:2];
                scan_rnw  = !((s_q.op == OP_DP_WR) || (s_q.op == OP_AP_WR));
                if (!scan_rnw) scan_wdata = s_q.wdata;
                if (is_ap(s_q.op) && mem_data_reg(s_q.addr)) scan_idle = cfg_idle_tck;
            end
            PH_CHK_CS: scan_addr = DPA_CSR;
            PH_CLR: begin
                scan_addr  = DPA_CSR;
                scan_rnw   = 1'b0;
                scan_wdata = s_q.wdata | STICKY_MASK;
            end
            PH_ABORT: begin
                scan_ir    = IR_ABORT;
                scan_addr  = 2'b00;
                scan_rnw   = 1'b0;
                scan_wdata = 32'h1;
            end
            default: ;
        endcase
    end

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        cache_upd     = 1'b0;
        tmr_clr       = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (req_valid) begin
                s_d.op    = op_e'(req_op);
                s_d.addr  = req_addr;
                s_d.wdata = req_wdata;
                s_d.apsel = req_apsel;
                s_d.rem   = (req_count == '0) ? ONE : req_count;
                s_d.pend  = 1'b0;
                unique case (op_e'(req_op))
                    OP_DP_RD, OP_DP_WR: s_d.phase = PH_ACC;
                    OP_AP_RD, OP_AP_WR, OP_AP_BLK:
                        s_d.phase = cache_hit ? PH_ACC : PH_SEL;
                    OP_ABORT: s_d.phase = PH_ABORT;
                    OP_CHECK: begin
                        s_d.phase = PH_CHK_CS;
                        tmr_clr   = 1'b1;
                    end
                    default: begin
                        s_d.rsp_valid  = 1'b1;
                        s_d.rsp_data   = '0;
                        s_d.rsp_status = ST_OK;
                        s_d.rsp_last   = 1'b1;
                    end
                endcase
            end
        end else if (!s_q.pend) begin
            if (scan_ready) s_d.pend = 1'b1;
        end else if (scan_rsp_valid) begin
            s_d.pend       = 1'b0;
            s_d.rsp_data   = scan_rsp_rdata;
            s_d.rsp_status = ST_OK;
            s_d.rsp_last   = 1'b1;
            unique case (s_q.phase)
                PH_SEL: begin
                    cache_upd = 1'b1;
                    s_d.phase = PH_ACC;
                end
                PH_ACC: begin
                    if ((s_q.op == OP_DP_WR) || (s_q.op == OP_AP_WR)) begin
                        s_d.phase     = PH_IDLE;
                        s_d.rsp_valid = 1'b1;
                        s_d.rsp_data  = '0;
                    end else if (s_q.op == OP_AP_BLK && s_q.rem != ONE) begin
                        s_d.phase = PH_BLK;
                    end else begin
                        s_d.phase = PH_RDB;
                    end
                end
                PH_BLK: begin
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_last  = 1'b0;
                    s_d.rem       = s_q.rem - ONE;
                    if (s_q.rem - ONE == ONE) s_d.phase = PH_RDB;
                end
                PH_RDB: begin
                    s_d.phase     = PH_IDLE;
                    s_d.rsp_valid = 1'b1;
                end
                PH_CHK_CS: s_d.phase = PH_CHK_RDB;
                PH_CHK_RDB: begin
                    s_d.phase = PH_IDLE;
                    if (scan_rsp_ack == ACK_WAIT) begin
                        if (tmr_exp) begin
                            s_d.rsp_valid  = 1'b1;
                            s_d.rsp_status = ST_TIMEOUT;
                        end else begin
                            s_d.phase = PH_CHK_CS;
                        end
                    end else if (scan_rsp_ack != ACK_OK) begin
                        s_d.rsp_valid  = 1'b1;
                        s_d.rsp_status = ST_BADACK;
                    end else if (scan_rsp_rdata[STICKY_ORUN_BIT] ||
                                 scan_rsp_rdata[STICKY_ERR_BIT]) begin
                        if (scan_rsp_rdata[31:28] != 4'hF) begin
                            s_d.rsp_valid  = 1'b1;
                            s_d.rsp_status = ST_REINIT;
                        end else begin
                            s_d.phase = PH_CLR;
                        end
                    end else begin
                        s_d.rsp_valid = 1'b1;
                    end
                end
                PH_CLR: begin
                    s_d.phase      = PH_IDLE;
                    s_d.rsp_valid  = 1'b1;
                    s_d.rsp_data   = s_q.rsp_data;
                    s_d.rsp_status = ST_STICKY;
                end
                PH_ABORT: begin
                    s_d.phase     = PH_IDLE;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_data  = '0;
                end
                default: s_d.phase = PH_IDLE;
            endcase
            if (s_q.phase == PH_CHK_RDB && s_d.phase == PH_CLR)
                s_d.rsp_data = scan_rsp_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.phase      <= PH_IDLE;
            s_q.op         <= OP_DP_RD;
            s_q.rsp_status <= ST_OK;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.phase == PH_IDLE);
    assign scan_valid = (s_q.phase != PH_IDLE) && !s_q.pend;
    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_data   = s_q.rsp_data;
    assign rsp_status = s_q.rsp_status;
    assign rsp_last   = s_q.rsp_last;

    // R13
    scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !scan_ready) |=> (scan_valid && $stable(scan_ir) &&
        $stable(scan_addr) && $stable(scan_rnw) && $stable(scan_wdata)));

    // R7
    abort_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_ir == IR_ABORT) |-> (scan_wdata == 32'h1 && !scan_rnw));

    // R6
    idle_ap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_idle != '0) |-> (scan_ir == IR_APACC));

    // R5
    last_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last) |-> req_ready);
endmodule

// File: tb/dbg_txn_seq_bench.sv
module dbg_txn_seq_bench;
    localparam int CNT_W = 8;
    localparam int IDLE_W = 8;
    localparam int TMO = 1000;
    localparam int LM = 2047;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [IDLE_W-1:0] cfg_idle_tck = 8'd5;
    logic req_valid = 0, req_ready;
    logic [2:0] req_op = 0;
    logic [7:0] req_addr = 0, req_apsel = 0;
    logic [31:0] req_wdata = 0;
    logic [CNT_W-1:0] req_count = 0;
    logic rsp_valid, rsp_last;
    logic [31:0] rsp_data;
    logic [2:0] rsp_status;
    logic scan_valid, scan_ready = 0, scan_rnw;
    logic [3:0] scan_ir;
    logic [1:0] scan_addr;
    logic [31:0] scan_wdata;
    logic [IDLE_W-1:0] scan_idle;
    logic scan_rsp_valid = 0;
    logic [2:0] scan_rsp_ack = 0;
    logic [31:0] scan_rsp_rdata = 0;

    dbg_txn_seq #(.CNT_W(CNT_W), .IDLE_W(IDLE_W), .TIMEOUT_CYC(TMO)) u_dbg_txn_seq (
        .clk(clk), .rst_n(rst_n), .cfg_idle_tck(cfg_idle_tck),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
        .req_apsel(req_apsel), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_status(rsp_status), .rsp_last(rsp_last), .scan_valid(scan_valid),
        .scan_ready(scan_ready), .scan_ir(scan_ir), .scan_addr(scan_addr),
        .scan_rnw(scan_rnw), .scan_wdata(scan_wdata), .scan_idle(scan_idle),
        .scan_rsp_valid(scan_rsp_valid), .scan_rsp_ack(scan_rsp_ack),
        .scan_rsp_rdata(scan_rsp_rdata));

    int tests = 0, fails = 0;

    // scan log
    int sc = 0;
    logic [3:0]  l_ir [0:LM];
    logic [1:0]  l_addr [0:LM];
    logic        l_rnw [0:LM];
    logic [31:0] l_wd [0:LM];
    logic [7:0]  l_idle [0:LM];
    // response log
    int rn = 0;
    logic [31:0] r_data [0:LM];
    logic [2:0]  r_st [0:LM];
    logic        r_last [0:LM];

    // responder controls
    logic        use_cs = 0;
    logic [31:0] cs_val = 0;
    int          wait_left = 0;
    logic [2:0]  ack_val = 3'b010;
    int          stall = 0;
    int          stab_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scan-side model
    initial begin
        int st = 0, dly = 0, idx = 0;
        bit seen = 0;
        logic [3:0] s_ir; logic [1:0] s_ad; logic s_rw; logic [31:0] s_wd;
        forever begin
            @(negedge clk);
            scan_ready = 0;
            scan_rsp_valid = 0;
            if (st == 0 && scan_valid) begin
                if (!seen) begin
                    seen = 1; s_ir = scan_ir; s_ad = scan_addr; s_rw = scan_rnw; s_wd = scan_wdata;
                end else if (s_ir != scan_ir || s_ad != scan_addr || s_rw != scan_rnw || s_wd != scan_wdata)
                    stab_err++;
                if (stall > 0) stall--;
                else begin
                    idx = sc & LM;
                    l_ir[idx] = scan_ir; l_addr[idx] = scan_addr; l_rnw[idx] = scan_rnw;
                    l_wd[idx] = scan_wdata; l_idle[idx] = scan_idle;
                    scan_ready = 1; st = 1; dly = 1; seen = 0;
                end
            end else if (st == 1) begin
                if (dly == 0) begin
                    scan_rsp_valid = 1;
                    if (use_cs && l_ir[idx] == 4'hA && l_addr[idx] == 2'b11) begin
                        scan_rsp_rdata = cs_val;
                        if (wait_left > 0) begin scan_rsp_ack = 3'b001; wait_left--; end
                        else scan_rsp_ack = ack_val;
                    end else begin
                        scan_rsp_rdata = 32'hD000_0000 + sc;
                        scan_rsp_ack = ack_val;
                    end
                    sc++; st = 0;
                end else dly--;
            end
        end
    end

    // response monitor
    initial forever begin
        @(negedge clk);
        if (rsp_valid) begin
            r_data[rn & LM] = rsp_data; r_st[rn & LM] = rsp_status; r_last[rn & LM] = rsp_last;
            rn++;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic do_req(input logic [2:0] op, input logic [7:0] a, input logic [31:0] wd,
                          input logic [7:0] cnt, input logic [7:0] aps, input int nrsp);
        int r0 = rn;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_addr = a; req_wdata = wd; req_count = cnt; req_apsel = aps;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        while (rn < r0 + nrsp || !req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_scan(input int i, input logic [3:0] ir, input logic [1:0] ad, input logic rw,
                            input logic [31:0] wd, input logic [7:0] idl, input string tag);
        chk(l_ir[i & LM] == ir, {tag, " ir"}, 32'(l_ir[i & LM]), 32'(ir));
        chk(l_addr[i & LM] == ad, {tag, " addr"}, 32'(l_addr[i & LM]), 32'(ad));
        chk(l_rnw[i & LM] == rw, {tag, " rnw"}, 32'(l_rnw[i & LM]), 32'(rw));
        if (!rw) chk(l_wd[i & LM] == wd, {tag, " wdata"}, l_wd[i & LM], wd);
        chk(l_idle[i & LM] == idl, {tag, " idle"}, 32'(l_idle[i & LM]), 32'(idl));
    endtask

    task automatic chk_rsp(input int i, input logic [31:0] d, input logic [2:0] stv, input logic lst, input string tag);
        chk(r_data[i & LM] == d, {tag, " data"}, r_data[i & LM], d);
        chk(r_st[i & LM] == stv, {tag, " status"}, 32'(r_st[i & LM]), 32'(stv));
        chk(r_last[i & LM] == lst, {tag, " last"}, 32'(r_last[i & LM]), 32'(lst));
    endtask

    task automatic t_reset();
        chk(req_ready == 1, "R1 req_ready", 32'(req_ready), 1);
        chk(scan_valid == 0, "R1 scan_valid", 32'(scan_valid), 0);
        chk(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
    endtask

    task automatic t_ap_read_first();
        int s = sc, r = rn;
        do_req(3'd2, 8'h0C, 0, 0, 8'h03, 1);
        chk(sc - s == 3, "R2 scan count", 32'(sc - s), 3);
        chk_scan(s, 4'hA, 2'b10, 0, 32'h0300_0000, 0, "R2 select");
        chk_scan(s + 1, 4'hB, 2'b11, 1, 0, 8'd5, "R3 R6 access");
        chk_scan(s + 2, 4'hA, 2'b11, 1, 0, 0, "R3 rdbuf");
        chk_rsp(r, 32'hD000_0000 + s + 2, 0, 1, "R3 rsp");
    endtask

    task automatic t_ap_read_same_bank();
        int s = sc, r = rn;
        do_req(3'd2, 8'h04, 0, 0, 8'h03, 1);
        chk(sc - s == 2, "R2 no select", 32'(sc - s), 2);
        chk_scan(s, 4'hB, 2'b01, 1, 0, 0, "R6 non-data idle");
        chk_rsp(r, 32'hD000_0000 + s + 1, 0, 1, "R3 rsp2");
    endtask

    task automatic t_ap_write();
        int s = sc, r = rn;
        do_req(3'd3, 8'h14, 32'h0000_1234, 0, 8'h03, 1);
        chk(sc - s == 2, "R2 R4 scan count", 32'(sc - s), 2);
        chk_scan(s, 4'hA, 2'b10, 0, 32'h0300_0010, 0, "R2 select bank1");
        chk_scan(s + 1, 4'hB, 2'b01, 0, 32'h0000_1234, 8'd5, "R4 R6 ap write");
        chk(r_st[r & LM] == 0, "R4 status", 32'(r_st[r & LM]), 0);
    endtask

    task automatic t_dp_write();
        int s = sc, r = rn;
        do_req(3'd1, 8'h04, 32'h5000_0000, 0, 8'h03, 1);
        chk(sc - s == 1, "R4 dp write count", 32'(sc - s), 1);
        chk_scan(s, 4'hA, 2'b01, 0, 32'h5000_0000, 0, "R4 dp write");
        chk(r_st[r & LM] == 0, "R4 dp status", 32'(r_st[r & LM]), 0);
    endtask

    task automatic t_block3();
        int s = sc, r = rn;
        do_req(3'd4, 8'h10, 0, 8'd3, 8'h03, 3);
        chk(sc - s == 4, "R5 scan count", 32'(sc - s), 4);
        for (int k = 0; k < 3; k++) chk_scan(s + k, 4'hB, 2'b00, 1, 0, 8'd5, "R5 R6 blk read");
        chk_scan(s + 3, 4'hA, 2'b11, 1, 0, 0, "R5 rdbuf");
        chk(rn - r == 3, "R5 rsp count", 32'(rn - r), 3);
        for (int k = 0; k < 3; k++)
            chk_rsp(r + k, 32'hD000_0000 + s + k + 1, 0, (k == 2), "R5 word");
    endtask

    task automatic t_block1();
        int s = sc, r = rn;
        do_req(3'd4, 8'h1C, 0, 8'd1, 8'h03, 1);
        chk(sc - s == 2, "R5 n1 count", 32'(sc - s), 2);
        chk_rsp(r, 32'hD000_0000 + s + 1, 0, 1, "R5 n1 word");
    endtask

    task automatic t_abort();
        int s = sc;
        do_req(3'd5, 0, 0, 0, 0, 1);
        chk(sc - s == 1, "R7 count", 32'(sc - s), 1);
        chk_scan(s, 4'h8, 2'b00, 0, 32'h1, 0, "R7 abort");
    endtask

    task automatic t_check(input logic [31:0] cs, input int waits, input logic [2:0] ackv,
                           input int exp_scans, input logic [2:0] exp_st, input string tag);
        int s = sc, r = rn;
        use_cs = 1; cs_val = cs; wait_left = waits; ack_val = ackv;
        do_req(3'd6, 0, 32'h5000_0000, 0, 0, 1);
        use_cs = 0; ack_val = 3'b010; wait_left = 0;
        if (exp_scans > 0) chk(sc - s == exp_scans, {tag, " scans"}, 32'(sc - s), 32'(exp_scans));
        chk(r_st[r & LM] == exp_st, {tag, " status"}, 32'(r_st[r & LM]), 32'(exp_st));
        chk_scan(s, 4'hA, 2'b01, 1, 0, 0, {tag, " csr read"});
        chk_scan(s + 1, 4'hA, 2'b11, 1, 0, 0, {tag, " rdbuf"});
        if (exp_st == 0) chk(r_data[r & LM] == cs, {tag, " data"}, r_data[r & LM], cs);
        if (exp_st == 3) chk_scan(s + 2, 4'hA, 2'b01, 0, 32'h5000_0022, 0, {tag, " clear"});
    endtask

    task automatic t_stall();
        int s = sc, r = rn;
        stall = 3; stab_err = 0;
        do_req(3'd0, 8'h00, 0, 0, 0, 1);
        chk(stab_err == 0, "R13 stable", 32'(stab_err), 0);
        chk(sc - s == 2, "R13 R3 count", 32'(sc - s), 2);
        chk_rsp(r, 32'hD000_0000 + s + 1, 0, 1, "R13 R3 rsp");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ap_read_first();
        t_ap_read_same_bank();
        t_ap_write();
        t_dp_write();
        t_block3();
        t_block1();
        t_abort();
        t_check(32'hF000_0000, 0, 3'b010, 2, 3'd0, "R8 ok");
        t_check(32'hF000_0000, 2, 3'b010, 6, 3'd0, "R9 retry");
        t_check(32'hF000_0000, 1000000, 3'b010, 0, 3'd2, "R9 timeout");
        t_check(32'hF000_0000, 0, 3'b100, 2, 3'd1, "R10 badack");
        t_check(32'hF000_0002, 0, 3'b010, 3, 3'd3, "R11 sticky");
        t_check(32'h0000_0020, 0, 3'b010, 2, 3'd4, "R12 reinit");
        t_stall();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule